// File: doc/BRIEF.md
# Two-Sided Channel Mailbox

This block lets two processors pass 32-bit messages to each other over eight independent channels. Every channel is a one-way queue of four entries. Each processor reaches the block through its own simple register port (select, write strobe, word address, write data, registered read data) and its own interrupt line. Both ports decode the same offsets; every port sees the block from its own side, so the "local" interrupt registers of one port are the "remote" ones of the other, and a channel that one side marks as transmit is a receive channel for the other side.

A sender sets a channel's direction, writes messages into the channel's data register, and can tell that the receiver has consumed them by watching the receiver's interrupt status through its remote status register. The receiver is interrupted while a channel holds data, pops messages by reading the data register, and can acknowledge only once the queue is empty, because a receive-pending bit refuses to clear while data remains.

Top module: `msg_mailbox`

## Requirements
- R1: After reset every queue is empty, all direction bits, enable bits and status bits are zero, both read data outputs are zero and both interrupt outputs are low.
- R2: Direction word g sits at byte offset 4*g and covers channels 4g..4g+3; channel n uses bit 8*(n%4) as its receive flag and bit 8*(n%4)+4 as its transmit flag. A flag written from one port appears in the opposite flag position when read through the other port.
- R3: A write to byte offset 0x180+4n by the side owning transmit for channel n pushes the word; a read of the same offset by the receiving side returns the oldest queued word and removes it, in first-in first-out order, up to four entries.
- R4: Byte offset 0x100+4n reads 1 in bit 0 when channel n holds four messages, else 0; byte offset 0x140+4n reads the number of queued messages (0 to 4) in bits [2:0].
- R5: A push to a full channel, or from the side not owning transmit, leaves the count and contents unchanged.
- R6: A data read of an empty channel, or by the side not owning receive, returns zero and leaves the queue unchanged.
- R7: In each side's 16-bit status (byte offset 0x70), bit 2n becomes 1 while that side receives on channel n and the queue is non-empty, and bit 2n+1 becomes 1 while that side transmits on channel n and the queue is not full; the enable word at byte offset 0x60 is read/write.
- R8: Writing 1 to a status bit at 0x70 clears it, except that a receive-pending bit stays 1 while its queue is non-empty.
- R9: Byte offsets 0x40 and 0x50 return the other side's enable and status words and ignore writes.
- R10: A port's interrupt is high exactly when some bit is 1 in both its status and its enable word.
- R11: Read data appears on the clock edge that takes the access and holds until the next read; writes take effect on that same edge, and status bits follow queue state one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 10 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 10 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
Every cycle the assertions check that no channel count exceeds four, that a full queue without a pop keeps its count and an empty queue without a push stays empty, that a non-empty queue raises the receiver's pending bit on the next edge, that a pending bit only falls after its queue has emptied, and that an interrupt line stays low when no enabled bit is set. Only the bench scenarios show first-in first-out data order, the mirrored direction and remote views between the two ports, zero data on illegal pops, the refused acknowledge while data remains, and delivery detection through the remote status word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // word indices (byte offset / 4) of the register windows
  localparam int W_REM_EN = 16;
  localparam int W_REM_ST = 20;
  localparam int W_LOC_EN = 24;
  localparam int W_LOC_ST = 28;
  localparam int W_FULL   = 64;
  localparam int W_COUNT  = 80;
  localparam int W_DATA   = 96;
  localparam int CH_PER_GRP = 4;

  function automatic int dir_rx_pos(int n);
    return 8 * (n % CH_PER_GRP);
  endfunction

  function automatic int dir_tx_pos(int n);
    return 8 * (n % CH_PER_GRP) + 4;
  endfunction

  function automatic int irq_rx_pos(int n);
    return 2 * n;
  endfunction

  function automatic int irq_tx_pos(int n);
    return 2 * n + 1;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign head = mem[rp];
  assign full = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 10,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = 2 * NCH,
  localparam int NGRP = (NCH + CH_PER_GRP - 1) / CH_PER_GRP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic [NCH-1:0]          own_tx,
  input  logic [NCH-1:0]          own_rx,
  input  logic [NCH-1:0]          full,
  input  logic [NCH-1:0][CW-1:0]  cnt,
  input  logic [NCH-1:0][DW-1:0]  head,
  input  logic [SW-1:0]           rem_en,
  input  logic [SW-1:0]           rem_stat,
  output logic [SW-1:0]           en_q,
  output logic [SW-1:0]           stat_q,
  output logic [NCH-1:0]          push,
  output logic [NCH-1:0]          pop,
  output logic [NGRP-1:0]         dir_we,
  output logic [DW-1:0]           rdata,
  output logic                    irq
);
  int            wi;
  logic          rd_acc, wr_acc;
  logic [SW-1:0] set_v, clr_v;
  logic [DW-1:0] rd_mux;
  logic          unused_bits;

  assign wi          = int'(addr[AW-1:2]);
  assign rd_acc      = sel & ~wr;
  assign wr_acc      = sel & wr;
  assign unused_bits = ^addr[1:0];
  assign irq         = |(stat_q & en_q);

  always_comb begin
    set_v  = '0;
    push   = '0;
    pop    = '0;
    dir_we = '0;
    for (int n = 0; n < NCH; n++) begin
      set_v[irq_rx_pos(n)] = own_rx[n] & (cnt[n] != '0);
      set_v[irq_tx_pos(n)] = own_tx[n] & ~full[n];
      push[n] = wr_acc & (wi == W_DATA + n) & own_tx[n] & ~full[n];
      pop[n]  = rd_acc & (wi == W_DATA + n) & own_rx[n] & (cnt[n] != '0);
    end
    for (int g = 0; g < NGRP; g++) dir_we[g] = wr_acc & (wi == g);
    clr_v = (wr_acc && wi == W_LOC_ST) ? wdata[SW-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NCH; n++) begin
      if (wi == n / CH_PER_GRP) begin
        rd_mux[dir_rx_pos(n)] = own_rx[n];
        rd_mux[dir_tx_pos(n)] = own_tx[n];
      end
      if (wi == W_FULL + n)  rd_mux = DW'(full[n]);
      if (wi == W_COUNT + n) rd_mux = DW'(cnt[n]);
      if (wi == W_DATA + n)  rd_mux = pop[n] ? head[n] : '0;
    end
    if (wi == W_REM_EN) rd_mux = DW'(rem_en);
    if (wi == W_REM_ST) rd_mux = DW'(rem_stat);
    if (wi == W_LOC_EN) rd_mux = DW'(en_q);
    if (wi == W_LOC_ST) rd_mux = DW'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      rdata  <= '0;
    end else begin
      stat_q <= set_v | (stat_q & ~clr_v);
      if (wr_acc && wi == W_LOC_EN) en_q <= wdata[SW-1:0];
      if (rd_acc) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbx_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 10,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = 2 * NCH,
  localparam int NGRP = (NCH + CH_PER_GRP - 1) / CH_PER_GRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  // direction is held from side A's point of view; side B sees it swapped
  logic [NCH-1:0]         a_tx, a_rx;
  logic [NCH-1:0]         ch_full, a_push, b_push, a_pop, b_pop, ch_push, ch_pop;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0][DW-1:0] ch_head;
  logic [SW-1:0]          a_en, b_en, a_stat, b_stat;
  logic [NGRP-1:0]        a_dir_we, b_dir_we;

  assign ch_push = a_push | b_push;
  assign ch_pop  = a_pop | b_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_tx <= '0;
      a_rx <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (a_dir_we[n / CH_PER_GRP]) begin
          a_rx[n] <= a_wdata[dir_rx_pos(n)];
          a_tx[n] <= a_wdata[dir_tx_pos(n)];
        end else if (b_dir_we[n / CH_PER_GRP]) begin
          a_rx[n] <= b_wdata[dir_tx_pos(n)];
          a_tx[n] <= b_wdata[dir_rx_pos(n)];
        end
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(ch_push[n]),
      .din(a_push[n] ? a_wdata : b_wdata),
      .pop(ch_pop[n]),
      .head(ch_head[n]),
      .cnt(ch_cnt[n]),
      .full(ch_full[n])
    );
  end

  mbx_port #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .sel(a_sel), .wr(a_wr), .addr(a_addr), .wdata(a_wdata),
    .own_tx(a_tx), .own_rx(a_rx),
    .full(ch_full), .cnt(ch_cnt), .head(ch_head),
    .rem_en(b_en), .rem_stat(b_stat),
    .en_q(a_en), .stat_q(a_stat),
    .push(a_push), .pop(a_pop), .dir_we(a_dir_we),
    .rdata(a_rdata), .irq(a_irq)
  );

  mbx_port #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .sel(b_sel), .wr(b_wr), .addr(b_addr), .wdata(b_wdata),
    .own_tx(a_rx), .own_rx(a_tx),
    .full(ch_full), .cnt(ch_cnt), .head(ch_head),
    .rem_en(a_en), .rem_stat(a_stat),
    .en_q(b_en), .stat_q(b_stat),
    .push(b_push), .pop(b_pop), .dir_we(b_dir_we),
    .rdata(b_rdata), .irq(b_irq)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = 2 * NCH
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0][CW-1:0] ch_cnt,
  input logic [NCH-1:0]         ch_full,
  input logic [NCH-1:0]         ch_push,
  input logic [NCH-1:0]         ch_pop,
  input logic [NCH-1:0]         a_tx,
  input logic [NCH-1:0]         a_rx,
  input logic [SW-1:0]          a_stat,
  input logic [SW-1:0]          b_stat,
  input logic [SW-1:0]          a_en,
  input logic [SW-1:0]          b_en,
  input logic                   a_irq,
  input logic                   b_irq
);
  for (genvar n = 0; n < NCH; n++) begin : g_c
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[n] <= CW'(DEPTH));
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_full[n] && !ch_pop[n] |=> $stable(ch_cnt[n]));
    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[n] == '0 && !ch_push[n] |=> ch_cnt[n] == '0);
    // R7
    a_rx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_rx[n] && ch_cnt[n] != '0 |=> a_stat[2*n]);
    // R7
    b_rx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_tx[n] && ch_cnt[n] != '0 |=> b_stat[2*n]);
    // R8
    a_pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_stat[2*n]) |-> $past(ch_cnt[n]) == '0);
    // R8
    b_pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_stat[2*n]) |-> $past(ch_cnt[n]) == '0);
  end

  // R10
  a_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_stat & a_en) == '0 |-> !a_irq);
  // R10
  b_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_stat & b_en) == '0 |-> !b_irq);
endmodule

bind msg_mailbox mbx_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ch_cnt(ch_cnt), .ch_full(ch_full), .ch_push(ch_push), .ch_pop(ch_pop),
  .a_tx(a_tx), .a_rx(a_rx), .a_stat(a_stat), .b_stat(b_stat),
  .a_en(a_en), .b_en(b_en), .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/sim_msg_mailbox.sv
module sim_msg_mailbox;
  logic        clk = 0, rst_n = 0;
  logic        a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [9:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          errors = 0, checks = 0;
  bit          done = 0;
  logic [31:0] rd, hold;

  always #5 clk = ~clk;

  msg_mailbox u0 (.*);

  typedef struct packed {
    logic        side;   // 0 = A, 1 = B
    logic        wr;
    logic        chk;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 1'b0, 12'h000, 32'h0000_0010, 32'h0, "R2 "}, // A: ch0 transmit
    '{1'b1, 1'b0, 1'b1, 12'h000, 32'h0, 32'h0000_0001, "R2 "}, // B sees receive
    '{1'b0, 1'b0, 1'b1, 12'h000, 32'h0, 32'h0000_0010, "R2 "},
    '{1'b0, 1'b1, 1'b0, 12'h180, 32'h1111_1111, 32'h0, "R3 "},
    '{1'b0, 1'b1, 1'b0, 12'h180, 32'h2222_2222, 32'h0, "R3 "},
    '{1'b1, 1'b0, 1'b1, 12'h140, 32'h0, 32'h0000_0002, "R4 "},
    '{1'b0, 1'b0, 1'b1, 12'h100, 32'h0, 32'h0000_0000, "R4 "},
    '{1'b0, 1'b0, 1'b1, 12'h180, 32'h0, 32'h0000_0000, "R6 "}, // A may not pop
    '{1'b1, 1'b0, 1'b1, 12'h180, 32'h0, 32'h1111_1111, "R3 "},
    '{1'b1, 1'b0, 1'b1, 12'h180, 32'h0, 32'h2222_2222, "R3 "},
    '{1'b1, 1'b0, 1'b1, 12'h180, 32'h0, 32'h0000_0000, "R6 "}, // empty pop
    '{1'b1, 1'b1, 1'b0, 12'h180, 32'h0000_DEAD, 32'h0, "R5 "}, // B not sender
    '{1'b0, 1'b0, 1'b1, 12'h140, 32'h0, 32'h0000_0000, "R5 "}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit side, input bit wr, input logic [11:0] addr,
                     input logic [31:0] wd, output logic [31:0] r);
    @(negedge clk);
    if (side) begin b_sel = 1; b_wr = wr; b_addr = addr[9:0]; b_wdata = wd; end
    else      begin a_sel = 1; a_wr = wr; a_addr = addr[9:0]; a_wdata = wd; end
    @(negedge clk);
    a_sel = 0; b_sel = 0; a_wr = 0; b_wr = 0;
    r = side ? b_rdata : a_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 a_rdata", a_rdata, 32'h0);
    check("R1 irq", {31'h0, a_irq | b_irq}, 32'h0);
    acc(0, 0, 12'h070, 0, rd); check("R1 A status", rd, 32'h0);
    acc(1, 0, 12'h060, 0, rd); check("R1 B enable", rd, 32'h0);
    acc(0, 0, 12'h004, 0, rd); check("R1 direction", rd, 32'h0);
    acc(1, 0, 12'h15C, 0, rd); check("R1 count ch7", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(TBL[i].side, TBL[i].wr, TBL[i].addr, TBL[i].wd, rd);
      if (TBL[i].chk) check($sformatf("%s row %0d", TBL[i].tag, i), rd, TBL[i].exp);
    end

    // R11 read data holds across idle cycles
    hold = rd;
    idle(3);
    check("R11 rdata hold", a_rdata, hold);

    // ch5 owned by B as sender (word 1, tx bit 12 from B's view)
    acc(1, 1, 12'h004, 32'h0000_1000, rd);
    acc(0, 0, 12'h004, 0, rd); check("R2 A view of ch5", rd, 32'h0000_0100);
    for (int k = 0; k < 5; k++) acc(1, 1, 12'h194, 32'hA000_0000 + k, rd);
    acc(0, 0, 12'h114, 0, rd); check("R4 full flag", rd, 32'h1);
    acc(0, 0, 12'h154, 0, rd); check("R5 count stays 4", rd, 32'h4);
    idle(2);
    acc(0, 1, 12'h060, 32'h0000_0400, rd);
    @(negedge clk);
    check("R10 A irq raised", {31'h0, a_irq}, 32'h1);
    acc(0, 0, 12'h070, 0, rd); check("R7 A rx pending ch5", rd & 32'h400, 32'h400);
    acc(0, 0, 12'h070, 0, rd); check("R7 A tx ch0", rd & 32'h2, 32'h2);
    acc(1, 0, 12'h050, 0, rd); check("R9 B remote status", rd & 32'h400, 32'h400);
    acc(1, 1, 12'h040, 32'h0, rd);
    acc(1, 0, 12'h040, 0, rd); check("R9 remote enable ro", rd, 32'h0000_0400);
    acc(0, 1, 12'h070, 32'h0000_0400, rd);
    idle(1);
    acc(0, 0, 12'h070, 0, rd); check("R8 clear refused", rd & 32'h400, 32'h400);
    acc(0, 0, 12'h194, 0, rd); check("R3 ch5 oldest", rd, 32'hA000_0000);
    acc(0, 0, 12'h114, 0, rd); check("R4 not full", rd, 32'h0);
    for (int k = 1; k < 4; k++) begin
      acc(0, 0, 12'h194, 0, rd); check("R3 ch5 order", rd, 32'hA000_0000 + k);
    end
    acc(0, 0, 12'h194, 0, rd); check("R5 fifth dropped", rd, 32'h0);
    acc(0, 1, 12'h070, 32'h0000_0400, rd);
    acc(0, 0, 12'h070, 0, rd); check("R8 clear after drain", rd & 32'h400, 32'h0);
    check("R10 A irq low", {31'h0, a_irq}, 32'h0);
    acc(1, 0, 12'h050, 0, rd); check("R9 delivery seen", rd & 32'h400, 32'h0);
    acc(1, 0, 12'h070, 0, rd); check("R7 B tx ch5", rd & 32'h800, 32'h800);
    check("R10 B irq low", {31'h0, b_irq}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule